// File: doc/BRIEF.md
# Pipelined 23-bit Floating-Point Multiplier

This block multiplies two numbers held in a compact 23-bit floating-point word. The word has a 6-bit exponent with a bias of 31, a sign bit, and a 16-bit stored fraction. The significand has an implied leading one. A valid strobe accompanies each operand pair. The block can accept a new pair on every clock. The product, with its own strobe, appears a fixed three cycles later.

The sign of the result is the exclusive-or of the operand signs. The exponents are added and the bias is removed once. The two 17-bit significands are multiplied. Because the product lies in [1, 4), a single optional right shift normalises it. The fraction is truncated, never rounded up. A result whose biased exponent falls below zero becomes the zero word. A result whose biased exponent exceeds the largest code saturates to the largest magnitude, with the computed sign kept. Denormal and special values are not represented: a word whose exponent and fraction are both zero means zero.

Top module: `fpm_mult`

## Requirements
- R1: `res_vld` equals `in_vld` delayed by exactly three rising clock edges.
- R2: For every non-zero result, bit 16 of `res_word` equals the exclusive-or of bit 16 of the two operands.
- R3: When neither operand is zero and the significand product {1,fa}×{1,fb} is below 2, the result holds these fields:
  - exponent field (bits 22:17): ea+eb−31;
  - fraction field (bits 15:0): product bits 31:16.
- R4: When the significand product is 2 or more (top bit 33 of the 34-bit product set), the result holds these fields:
  - exponent field: ea+eb−30;
  - fraction field: product bits 32:17, the 16 bits below the leading one.
- R5: Product bits below the kept fraction are discarded without rounding. For example, fa=fb=0x0001 gives fraction 0x0002.
- R6: If either operand has exponent field 0 and fraction field 0, the result is the all-zero word.
- R7: If the final biased exponent is below 0, the result is the all-zero word.
- R8: If the final biased exponent exceeds 63, the result has exponent field 63, fraction field 0xFFFF and the exclusive-or sign.
- R9: Pairs presented on consecutive cycles each produce their own correct result on consecutive cycles.
- R10: While `rst_n` is low, `res_vld` and `res_word` read 0 after the next rising edge, whatever `in_vld` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand pair is valid this cycle |
| op_a | input | 23 | First operand {exp[22:17], sign[16], frac[15:0]} |
| op_b | input | 23 | Second operand, same layout |
| res_vld | output | 1 | Product is valid this cycle |
| res_word | output | 23 | Product, same layout |

## Verification
Each stage register holds one operand pair in flight, so a wrong value in any of them reaches `res_word` or `res_vld` within three cycles and affects only that one result. The following faults show up in the first affected product:
- a wrongly captured exponent sum shows as an off-by-bias or off-by-one exponent field;
- a wrong normalisation select shows as a fraction shifted by one bit together with an exponent one away from the expected value;
- a wrong zero or range flag shows as a spurious zero or saturated word.

A stuck valid stage shows as `res_vld` out of step with `in_vld` three cycles earlier.

// File: rtl/fpm_pkg.sv
// Package: shared defaults and the result classification used by the
// floating-point multiplier stages. Assumes the word layout
// {exponent, sign, fraction} with the exponent in the top bits.
package fpm_pkg;

    localparam int DEF_EXP_W = 6;
    localparam int DEF_MAN_W = 16;
    localparam int DEF_BIAS  = 31;
    localparam int PIPE_LAT  = 3;

    // How the final stage forms the output word.
    typedef enum logic [1:0] {
        RC_NORMAL = 2'd0,
        RC_ZERO   = 2'd1,
        RC_UFLOW  = 2'd2,
        RC_OFLOW  = 2'd3
    } res_class_t;

endpackage

// File: rtl/fpm_unpack.sv
// Stage 1: splits both operands, detects zero operands, forms the result
// sign and the biased exponent sum with the bias removed once.
// Assumes BIAS < 2**EXP_W so the signed sum fits in EXP_W+2 bits.
module fpm_unpack #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 16,
    parameter int BIAS  = 31,
    localparam int WORD_W = EXP_W + 1 + MAN_W,
    localparam int SIG_W  = MAN_W + 1,
    localparam int ESUM_W = EXP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [WORD_W-1:0]        op_a,
    input  logic [WORD_W-1:0]        op_b,
    output logic                     s1_vld,
    output logic                     s1_zero,
    output logic                     s1_sgn,
    output logic signed [ESUM_W-1:0] s1_esum,
    output logic [SIG_W-1:0]         s1_siga,
    output logic [SIG_W-1:0]         s1_sigb
);

    logic [WORD_W-1:0] ops [2];
    logic [EXP_W-1:0]  exps [2];
    logic [SIG_W-1:0]  sigs [2];
    logic [1:0]        is_zero;
    logic [1:0]        sgns;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // Field extraction is identical for each operand.
    for (genvar g = 0; g < 2; g++) begin : g_opnd
        assign exps[g]    = ops[g][WORD_W-1 -: EXP_W];
        assign sgns[g]    = ops[g][MAN_W];
        assign sigs[g]    = {1'b1, ops[g][MAN_W-1:0]};
        assign is_zero[g] = (ops[g][WORD_W-1 -: EXP_W] == '0) && (ops[g][MAN_W-1:0] == '0);
    end

    logic signed [ESUM_W-1:0] esum_c;

    // Exponent sum with the bias taken off once.
    always_comb begin
        esum_c = $signed(ESUM_W'(exps[0])) + $signed(ESUM_W'(exps[1])) - $signed(ESUM_W'(BIAS));
    end

    // Register the unpacked operand pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_zero <= 1'b0;
            s1_sgn  <= 1'b0;
            s1_esum <= '0;
            s1_siga <= '0;
            s1_sigb <= '0;
        end else begin
            s1_vld  <= in_vld;
            s1_zero <= |is_zero;
            s1_sgn  <= ^sgns;
            s1_esum <= esum_c;
            s1_siga <= sigs[0];
            s1_sigb <= sigs[1];
        end
    end

endmodule

// File: rtl/fpm_sigmul.sv
// Stage 2: multiplies the two significands (each with its hidden one) and
// carries the side information forward. Assumes one multiplier primitive
// can absorb a SIG_W x SIG_W product in one cycle.
module fpm_sigmul #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 16,
    localparam int SIG_W  = MAN_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int ESUM_W = EXP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_vld,
    input  logic                     s1_zero,
    input  logic                     s1_sgn,
    input  logic signed [ESUM_W-1:0] s1_esum,
    input  logic [SIG_W-1:0]         s1_siga,
    input  logic [SIG_W-1:0]         s1_sigb,
    output logic                     s2_vld,
    output logic                     s2_zero,
    output logic                     s2_sgn,
    output logic signed [ESUM_W-1:0] s2_esum,
    output logic [PROD_W-1:0]        s2_prod
);

    logic [PROD_W-1:0] prod_c;

    // Full-width unsigned significand product.
    always_comb begin
        prod_c = PROD_W'(s1_siga) * PROD_W'(s1_sigb);
    end

    // Register the product and the side fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_zero <= 1'b0;
            s2_sgn  <= 1'b0;
            s2_esum <= '0;
            s2_prod <= '0;
        end else begin
            s2_vld  <= s1_vld;
            s2_zero <= s1_zero;
            s2_sgn  <= s1_sgn;
            s2_esum <= s1_esum;
            s2_prod <= prod_c;
        end
    end

endmodule

// File: rtl/fpm_normpack.sv
// Stage 3: normalises the product by at most one place, applies the
// exponent carry, classifies zero / underflow / overflow and packs the
// output word. Assumes the product of two significands lies in [1,4).
module fpm_normpack #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 16,
    localparam int WORD_W = EXP_W + 1 + MAN_W,
    localparam int SIG_W  = MAN_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int ESUM_W = EXP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s2_vld,
    input  logic                     s2_zero,
    input  logic                     s2_sgn,
    input  logic signed [ESUM_W-1:0] s2_esum,
    input  logic [PROD_W-1:0]        s2_prod,
    output logic                     res_vld,
    output logic [WORD_W-1:0]        res_word
);

    import fpm_pkg::*;

    logic                     norm_up;
    logic signed [ESUM_W-1:0] efin;
    logic [MAN_W-1:0]         frac;
    res_class_t               rclass;
    logic [WORD_W-1:0]        word_c;

    // Pick the fraction window below the leading one and adjust exponent.
    always_comb begin
        norm_up = s2_prod[PROD_W-1];
        efin    = s2_esum + $signed({{(ESUM_W-1){1'b0}}, norm_up});
        frac    = norm_up ? s2_prod[PROD_W-2 -: MAN_W] : s2_prod[PROD_W-3 -: MAN_W];
    end

    // Classify the result; zero operands take precedence.
    always_comb begin
        if (s2_zero)
            rclass = RC_ZERO;
        else if (efin[ESUM_W-1])
            rclass = RC_UFLOW;
        else if (efin[ESUM_W-2:EXP_W] != '0)
            rclass = RC_OFLOW;
        else
            rclass = RC_NORMAL;
    end

    // Form the output word from the class.
    always_comb begin
        unique case (rclass)
            RC_NORMAL: word_c = {efin[EXP_W-1:0], s2_sgn, frac};
            RC_OFLOW:  word_c = {{EXP_W{1'b1}}, s2_sgn, {MAN_W{1'b1}}};
            default:   word_c = '0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_word <= '0;
        end else begin
            res_vld  <= s2_vld;
            res_word <= word_c;
        end
    end

endmodule

// File: rtl/fpm_mult.sv
// Top: three-stage floating-point multiplier for the
// {exponent, sign, fraction} word with a hidden leading one.
// Accepts one operand pair per clock; result follows three cycles later.
// Assumes no denormal or special codes; truncates, flushes, saturates.
module fpm_mult #(
    parameter int EXP_W = fpm_pkg::DEF_EXP_W,
    parameter int MAN_W = fpm_pkg::DEF_MAN_W,
    parameter int BIAS  = fpm_pkg::DEF_BIAS,
    localparam int WORD_W = EXP_W + 1 + MAN_W,
    localparam int SIG_W  = MAN_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int ESUM_W = EXP_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              res_vld,
    output logic [WORD_W-1:0] res_word
);

    logic                     s1_vld, s1_zero, s1_sgn;
    logic signed [ESUM_W-1:0] s1_esum;
    logic [SIG_W-1:0]         s1_siga, s1_sigb;
    logic                     s2_vld, s2_zero, s2_sgn;
    logic signed [ESUM_W-1:0] s2_esum;
    logic [PROD_W-1:0]        s2_prod;

    fpm_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) u_unpack (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .s1_vld(s1_vld), .s1_zero(s1_zero), .s1_sgn(s1_sgn), .s1_esum(s1_esum),
        .s1_siga(s1_siga), .s1_sigb(s1_sigb)
    );

    fpm_sigmul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sigmul (
        .clk(clk), .rst_n(rst_n),
        .s1_vld(s1_vld), .s1_zero(s1_zero), .s1_sgn(s1_sgn), .s1_esum(s1_esum),
        .s1_siga(s1_siga), .s1_sigb(s1_sigb),
        .s2_vld(s2_vld), .s2_zero(s2_zero), .s2_sgn(s2_sgn), .s2_esum(s2_esum),
        .s2_prod(s2_prod)
    );

    fpm_normpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_normpack (
        .clk(clk), .rst_n(rst_n),
        .s2_vld(s2_vld), .s2_zero(s2_zero), .s2_sgn(s2_sgn), .s2_esum(s2_esum),
        .s2_prod(s2_prod),
        .res_vld(res_vld), .res_word(res_word)
    );

endmodule

// File: rtl/fpm_mult_chk.sv
// Checker: port-level properties of the multiplier, bound to fpm_mult.
// Assumes the fixed three-cycle latency of the top module.
module fpm_mult_chk #(
    parameter int EXP_W = 6,
    parameter int MAN_W = 16,
    parameter int BIAS  = 31,
    localparam int WORD_W = EXP_W + 1 + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              res_vld,
    input logic [WORD_W-1:0] res_word
);

    logic [EXP_W:0] exp_sum;
    logic           a_zero, b_zero, any_zero;
    logic [1:0]     since_rst;
    logic           rst_seen;

    // Port-side operand decode used by the properties.
    always_comb begin
        exp_sum  = {1'b0, op_a[WORD_W-1 -: EXP_W]} + {1'b0, op_b[WORD_W-1 -: EXP_W]};
        a_zero   = (op_a[WORD_W-1 -: EXP_W] == '0) && (op_a[MAN_W-1:0] == '0);
        b_zero   = (op_b[WORD_W-1 -: EXP_W] == '0) && (op_b[MAN_W-1:0] == '0);
        any_zero = a_zero || b_zero;
    end

    // Count cycles since reset, capped, so latency checks start cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Remember that the last edge saw reset asserted.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    p_vld_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (res_vld == $past(in_vld, 3)));

    p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !any_zero) |-> ##3
        ((res_word == '0) || (res_word[MAN_W] == $past(op_a[MAN_W] ^ op_b[MAN_W], 3))));

    p_zero_opnd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && any_zero) |-> ##3 (res_vld && res_word == '0));

    p_uflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !any_zero && (int'(exp_sum) <= BIAS - 2)) |-> ##3 (res_word == '0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !any_zero && (int'(exp_sum) >= BIAS + (1 << EXP_W))) |-> ##3
        (res_word[WORD_W-1 -: EXP_W] == '1 && res_word[MAN_W-1:0] == '1));

    // Output is cleared by an edge taken in reset.
    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            p_rst_clear_r10: assert (!res_vld && res_word == '0);
        end
    end

endmodule

bind fpm_mult fpm_mult_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .res_vld(res_vld), .res_word(res_word)
);

// File: tb/fpm_mult_tb_top.sv
`timescale 1ns/1ps
module fpm_mult_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [22:0] op_a = '0;
    logic [22:0] op_b = '0;
    logic        res_vld;
    logic [22:0] res_word;

    int n_cmp = 0;
    int n_bad = 0;
    int n = 0;
    logic        h_vld [4];
    logic [22:0] h_res [4];
    string       h_tag [4];

    always #2.5 clk = ~clk;

    fpm_mult dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .res_vld(res_vld), .res_word(res_word)
    );

    function automatic logic [22:0] mk(input int e, input bit s, input int f);
        return {e[5:0], s, f[15:0]};
    endfunction

    // Reference product from the requirements.
    function automatic logic [22:0] ref_mul(input logic [22:0] a, input logic [22:0] b);
        longint sig;
        int     e, c;
        logic [15:0] fr;
        logic   s;
        if ((a[22:17] == 0 && a[15:0] == 0) || (b[22:17] == 0 && b[15:0] == 0)) return '0;
        s   = a[16] ^ b[16];
        sig = longint'({1'b1, a[15:0]}) * longint'({1'b1, b[15:0]});
        c   = int'((sig >> 33) & 1);
        e   = int'(a[22:17]) + int'(b[22:17]) - 31 + c;
        fr  = (c != 0) ? 16'((sig >> 17) & 64'hFFFF) : 16'((sig >> 16) & 64'hFFFF);
        if (e < 0) return '0;
        if (e > 63) return {6'h3F, s, 16'hFFFF};
        return {e[5:0], s, fr};
    endfunction

    // Requirement tag for a pair.
    function automatic string ref_tag(input logic [22:0] a, input logic [22:0] b);
        longint sig;
        int e;
        if ((a[22:17] == 0 && a[15:0] == 0) || (b[22:17] == 0 && b[15:0] == 0)) return "R6";
        sig = longint'({1'b1, a[15:0]}) * longint'({1'b1, b[15:0]});
        e   = int'(a[22:17]) + int'(b[22:17]) - 31 + int'((sig >> 33) & 1);
        if (e < 0) return "R7";
        if (e > 63) return "R8";
        return ((sig >> 33) & 1) != 0 ? "R4" : "R3";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [22:0] act, input logic [22:0] exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
        end
    endtask

    // One cycle: check the result of the pair driven three steps earlier, then drive.
    task automatic step(input logic v, input logic [22:0] a, input logic [22:0] b, input string tag);
        int s;
        @(negedge clk);
        s = (n + 1) % 4;
        check(res_vld == h_vld[s], "R1", 23'(res_vld), 23'(h_vld[s]));
        if (h_vld[s]) begin
            check(res_word == h_res[s], h_tag[s], res_word, h_res[s]);
            if (h_res[s] != '0)
                check(res_word[16] == h_res[s][16], "R2", 23'(res_word[16]), 23'(h_res[s][16]));
        end
        in_vld = v;
        op_a   = a;
        op_b   = b;
        h_vld[n % 4] = v;
        h_res[n % 4] = ref_mul(a, b);
        h_tag[n % 4] = (tag == "") ? ref_tag(a, b) : tag;
        n++;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int unused;
        unused = $urandom(32'h5EED_0042);
        for (int i = 0; i < 4; i++) begin
            h_vld[i] = 1'b0;
            h_res[i] = '0;
            h_tag[i] = "R1";
        end
        // R10: reset holds outputs low even with valid input.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_vld = 1'b1;
            op_a   = mk(31, 0, 0);
            op_b   = mk(31, 0, 0);
            if (i > 0) begin
                check(res_vld == 1'b0, "R10", 23'(res_vld), 23'd0);
                check(res_word == '0, "R10", res_word, '0);
            end
        end
        @(negedge clk);
        rst_n  = 1'b1;
        in_vld = 1'b0;

        step(1, mk(31, 0, 0),      mk(31, 0, 0),      "R3");  // 1.0 * 1.0
        step(1, mk(31, 1, 16'h8000), mk(31, 0, 16'h8000), "R4");  // -1.5 * 1.5 carry
        step(1, mk(31, 0, 1),      mk(31, 0, 1),      "R5");  // truncated low bit
        step(1, mk(40, 1, 16'hFFFF), mk(20, 1, 16'hFFFF), "R5");
        step(0, mk(50, 0, 3),      mk(50, 0, 3),      "R1");  // ignored: not valid
        step(1, mk(0, 0, 0),       mk(45, 1, 16'h1234), "R6");
        step(1, mk(33, 1, 7),      mk(0, 0, 0),       "R6");
        step(1, mk(10, 0, 5),      mk(10, 0, 5),      "R7");
        step(1, mk(15, 0, 0),      mk(15, 0, 0),      "R7");  // 30-31 = -1
        step(1, mk(16, 0, 0),      mk(15, 1, 16'hFFFF), "R3");  // exponent 0, nonzero frac
        step(1, mk(63, 0, 0),      mk(31, 1, 0),      "R3");  // exactly 63
        step(1, mk(63, 0, 16'h8000), mk(31, 0, 16'h8000), "R8"); // carry to 64
        step(1, mk(63, 1, 9),      mk(63, 0, 9),      "R8");
        // R9: back-to-back burst of distinct pairs.
        for (int i = 0; i < 8; i++)
            step(1, mk(28 + i, i[0], 1000 * i), mk(30 - i, i[1], 16'hF00F ^ i), "R9");
        // Constrained random mix.
        for (int i = 0; i < 3000; i++) begin
            logic [22:0] a, b;
            a = 23'($urandom);
            b = 23'($urandom);
            if ($urandom % 16 == 0) a = '0;
            if ($urandom % 8 == 0) a[22:17] = 6'(20 + $urandom % 24);
            if ($urandom % 8 == 0) b[22:17] = 6'(20 + $urandom % 24);
            step(($urandom % 4) != 0, a, b, "");
        end
        for (int i = 0; i < 4; i++) step(0, '0, '0, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule